// File: doc/BRIEF.md
# Width-Converting Stream FIFO with Null-Beat Filtering

This block is a single-clock stream buffer whose write side and read side carry data of different widths, one an integer power-of-two multiple of the other. Storage is a set of equal-width FIFO lanes, each as wide as the narrower side. The wider side spans all lanes at once. The narrower side walks the lanes one at a time, lowest lane first. When narrowing, a wide input beat is cut into narrow output words. When widening, narrow input beats are packed into a wide output word, and a packet end closes the word early.

With the keep filter enabled, an input beat whose byte-keep bits are all zero and whose last flag is low is accepted and thrown away. A beat that carries the last flag is always stored, even with no valid bytes. Filtering happens entirely on the write side, so the output valid never waits for the output ready.

Free space (`room`, counted in input words) and stored data (`level`, counted in output words) come from two dedicated up/down counters rather than from a sum over the lanes. Discarded beats leave both counters untouched. The input ready is the room counter being nonzero, and the output valid is the level counter being nonzero.

Top module: `stream_width_fifo`

## Requirements
- R1: After a synchronous active-low reset, `room` equals its maximum (`LANE_DEPTH` when narrowing, `LANES*LANE_DEPTH` when widening), `level` is 0, `out_valid` is 0 and `in_ready` is 1.
- R2: `in_ready` is low exactly when `room` is zero, and `out_valid` is high exactly when `level` is nonzero.
- R3: When narrowing, byte lane i of a wide input beat (data bits [8*OUT_BYTES*(i+1)-1 : 8*OUT_BYTES*i] and the keep bits of the same bytes) is delivered as the i-th narrow word, for i rising from 0. `out_last` is high only on the final narrow word of a beat that had `in_last` high.
- R4: When widening, successive stored narrow beats fill output lanes 0, 1, 2, and so on. A word is complete when its top lane is filled or when a beat with `in_last` high arrives. An early-closed word has data and keep zero in its unfilled lanes and has `out_last` high.
- R5: With `KEEP_FILTER` = 1, a beat accepted with `in_keep` all zero and `in_last` low produces no output and changes neither `room` nor `level`.
- R6: A beat with `in_last` high is stored and delivered even when `in_keep` is all zero.
- R7: Once `out_valid` is high it stays high, with `out_data`, `out_keep` and `out_last` unchanged, until a cycle with `out_ready` high.
- R8: `room` changes as follows. When narrowing, it drops by 1 per stored beat and rises by 1 when the final narrow word of a beat is taken. When widening, it drops by 1 per stored beat plus one for every lane an early close leaves unfilled, and it rises by `LANES` per output handshake.
- R9: `level` changes as follows. It rises by `LANES` per stored wide beat when narrowing, or by 1 per completed wide word when widening, and it drops by 1 per output handshake.
- R10: `room` never exceeds its maximum and `level` never exceeds its maximum (`LANES*LANE_DEPTH` narrowing, `LANE_DEPTH` widening). A full buffer holds `in_ready` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | 8*IN_BYTES | Input beat data |
| in_keep | input | IN_BYTES | Input byte-keep mask |
| in_last | input | 1 | Input packet end |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Input beat can be taken |
| out_data | output | 8*OUT_BYTES | Output word data |
| out_keep | output | OUT_BYTES | Output byte-keep mask |
| out_last | output | 1 | Output packet end |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Downstream takes the word |
| room | output | ROOM_W | Free space in input words |
| level | output | LEVEL_W | Stored data in output words |

## Verification
The assertions check on every cycle that both counters stay within their bounds, that a waiting output word holds valid and its contents, that an accepted null beat leaves both counters still, and that an output handshake without input lowers the level by exactly one. Only the bench's scenarios can show that byte lanes come out in the right order, that early-closed wide words carry zeroed lanes and the last flag, that last-flagged empty beats survive filtering, and that the room bookkeeping matches the data actually delivered. For this, a behavioural queue model runs both a narrowing and a widening instance through fill, drain and mixed random traffic.

// File: rtl/swf_pkg.sv
package swf_pkg;

    // number of narrow lanes spanned by the wide side
    function automatic int lane_count(int in_b, int out_b);
        return (in_b > out_b) ? (in_b / out_b) : (out_b / in_b);
    endfunction

    // free-space capacity, counted in input words
    function automatic int room_limit(int in_b, int out_b, int depth);
        return (out_b > in_b) ? lane_count(in_b, out_b) * depth : depth;
    endfunction

    // stored-data capacity, counted in output words
    function automatic int level_limit(int in_b, int out_b, int depth);
        return (out_b > in_b) ? depth : lane_count(in_b, out_b) * depth;
    endfunction

endpackage

// File: rtl/swf_lane.sv
module swf_lane #(
    parameter int W     = 8,
    parameter int DEPTH = 4,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_word,
    input  logic         rd_en,
    output logic [W-1:0] rd_word
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
    } ptr_t;

    ptr_t         ptr_d, ptr_q;
    logic [W-1:0] mem [DEPTH];

    always_comb begin
        ptr_d = ptr_q;
        if (wr_en) ptr_d.wp = ptr_q.wp + AW'(1);
        if (rd_en) ptr_d.rp = ptr_q.rp + AW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[ptr_q.wp] <= wr_word;
    end

    assign rd_word = mem[ptr_q.rp];
endmodule

// File: rtl/swf_occupancy.sv
module swf_occupancy #(
    parameter int RW        = 3,
    parameter int LW        = 5,
    parameter int ROOM_INIT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] room_sub,
    input  logic [RW-1:0] room_add,
    input  logic [LW-1:0] level_add,
    input  logic          level_sub,
    output logic [RW-1:0] room,
    output logic [LW-1:0] level
);
    typedef struct packed {
        logic [RW-1:0] room;
        logic [LW-1:0] level;
    } occ_t;

    occ_t occ_d, occ_q;

    always_comb begin
        occ_d       = occ_q;
        occ_d.room  = occ_q.room - room_sub + room_add;
        occ_d.level = occ_q.level + level_add - LW'(level_sub);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q.room  <= RW'(ROOM_INIT);
            occ_q.level <= '0;
        end else begin
            occ_q <= occ_d;
        end
    end

    assign room  = occ_q.room;
    assign level = occ_q.level;
endmodule

// File: rtl/stream_width_fifo.sv
module stream_width_fifo import swf_pkg::*; #(
    parameter int IN_BYTES    = 4,
    parameter int OUT_BYTES   = 1,
    parameter int LANE_DEPTH  = 4,
    parameter int KEEP_FILTER = 1,
    localparam int ROOM_W  = $clog2(room_limit(IN_BYTES, OUT_BYTES, LANE_DEPTH) + 1),
    localparam int LEVEL_W = $clog2(level_limit(IN_BYTES, OUT_BYTES, LANE_DEPTH) + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [8*IN_BYTES-1:0]  in_data,
    input  logic [IN_BYTES-1:0]    in_keep,
    input  logic                   in_last,
    input  logic                   in_valid,
    output logic                   in_ready,
    output logic [8*OUT_BYTES-1:0] out_data,
    output logic [OUT_BYTES-1:0]   out_keep,
    output logic                   out_last,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [ROOM_W-1:0]      room,
    output logic [LEVEL_W-1:0]     level
);
    localparam bit WIDEN      = OUT_BYTES > IN_BYTES;
    localparam int LANES      = lane_count(IN_BYTES, OUT_BYTES);
    localparam int LANE_BYTES = WIDEN ? IN_BYTES : OUT_BYTES;
    localparam int LANE_DW    = 8 * LANE_BYTES;
    localparam int IDX_W      = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int ROOM_MAX   = room_limit(IN_BYTES, OUT_BYTES, LANE_DEPTH);

    typedef struct packed {
        logic                  last;
        logic [LANE_BYTES-1:0] keep;
        logic [LANE_DW-1:0]    data;
    } entry_t;

    typedef struct packed {
        logic [IDX_W-1:0] wr_idx;   // next lane to fill (widening)
        logic [IDX_W-1:0] rd_idx;   // next lane to drain (narrowing)
    } ctl_t;

    ctl_t               ctl_d, ctl_q;
    logic [LANES-1:0]   lane_we, lane_re;
    entry_t             lane_win  [LANES];
    entry_t             lane_rout [LANES];
    logic [ROOM_W-1:0]  room_sub, room_add;
    logic [LEVEL_W-1:0] level_add;
    logic               drop, accept, store, pop;

    assign in_ready  = (room != '0);
    assign out_valid = (level != '0);
    assign drop      = (KEEP_FILTER != 0) && (in_keep == '0) && !in_last;
    assign accept    = in_valid && in_ready;
    assign store     = accept && !drop;
    assign pop       = out_valid && out_ready;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        swf_lane #(
            .W     ($bits(entry_t)),
            .DEPTH (LANE_DEPTH)
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (lane_we[g]),
            .wr_word (lane_win[g]),
            .rd_en   (lane_re[g]),
            .rd_word (lane_rout[g])
        );
    end

    if (WIDEN) begin : g_widen
        always_comb begin
            ctl_d     = ctl_q;
            room_sub  = '0;
            room_add  = '0;
            level_add = '0;
            lane_we   = '0;
            lane_re   = '0;
            for (int i = 0; i < LANES; i++) begin
                // filler for lanes an early close leaves empty
                lane_win[i] = '{last: 1'b1, keep: '0, data: '0};
                if (IDX_W'(i) == ctl_q.wr_idx)
                    lane_win[i] = '{last: in_last, keep: in_keep, data: in_data};
                lane_we[i] = store && ((IDX_W'(i) == ctl_q.wr_idx) ||
                                       (in_last && (IDX_W'(i) > ctl_q.wr_idx)));
                lane_re[i] = pop;
                out_data[i*LANE_DW +: LANE_DW]    = lane_rout[i].data;
                out_keep[i*LANE_BYTES +: LANE_BYTES] = lane_rout[i].keep;
            end
            out_last = lane_rout[LANES-1].last;
            if (store) begin
                room_sub = in_last ? (ROOM_W'(LANES) - ROOM_W'(ctl_q.wr_idx)) : ROOM_W'(1);
                if (in_last || (ctl_q.wr_idx == IDX_W'(LANES - 1))) begin
                    level_add    = LEVEL_W'(1);
                    ctl_d.wr_idx = '0;
                end else begin
                    ctl_d.wr_idx = ctl_q.wr_idx + IDX_W'(1);
                end
            end
            if (pop) room_add = ROOM_W'(LANES);
        end
    end else begin : g_narrow
        always_comb begin
            ctl_d     = ctl_q;
            room_sub  = '0;
            room_add  = '0;
            level_add = '0;
            lane_we   = '0;
            lane_re   = '0;
            for (int i = 0; i < LANES; i++) begin
                lane_win[i] = '{last: in_last && (i == LANES - 1),
                                keep: in_keep[i*LANE_BYTES +: LANE_BYTES],
                                data: in_data[i*LANE_DW +: LANE_DW]};
                lane_we[i] = store;
                lane_re[i] = pop && (ctl_q.rd_idx == IDX_W'(i));
            end
            out_data = lane_rout[ctl_q.rd_idx].data;
            out_keep = lane_rout[ctl_q.rd_idx].keep;
            out_last = lane_rout[ctl_q.rd_idx].last;
            if (store) begin
                room_sub  = ROOM_W'(1);
                level_add = LEVEL_W'(LANES);
            end
            if (pop) begin
                if (ctl_q.rd_idx == IDX_W'(LANES - 1)) begin
                    room_add     = ROOM_W'(1);
                    ctl_d.rd_idx = '0;
                end else begin
                    ctl_d.rd_idx = ctl_q.rd_idx + IDX_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    swf_occupancy #(
        .RW        (ROOM_W),
        .LW        (LEVEL_W),
        .ROOM_INIT (ROOM_MAX)
    ) u_occ (
        .clk       (clk),
        .rst_n     (rst_n),
        .room_sub  (room_sub),
        .room_add  (room_add),
        .level_add (level_add),
        .level_sub (pop),
        .room      (room),
        .level     (level)
    );
endmodule

// File: rtl/stream_width_fifo_chk.sv
module stream_width_fifo_chk import swf_pkg::*; #(
    parameter int IN_BYTES    = 4,
    parameter int OUT_BYTES   = 1,
    parameter int LANE_DEPTH  = 4,
    parameter int KEEP_FILTER = 1,
    localparam int ROOM_MAX  = room_limit(IN_BYTES, OUT_BYTES, LANE_DEPTH),
    localparam int LEVEL_MAX = level_limit(IN_BYTES, OUT_BYTES, LANE_DEPTH),
    localparam int ROOM_W    = $clog2(ROOM_MAX + 1),
    localparam int LEVEL_W   = $clog2(LEVEL_MAX + 1)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [IN_BYTES-1:0]    in_keep,
    input logic                   in_last,
    input logic                   in_valid,
    input logic                   in_ready,
    input logic [8*OUT_BYTES-1:0] out_data,
    input logic [OUT_BYTES-1:0]   out_keep,
    input logic                   out_last,
    input logic                   out_valid,
    input logic                   out_ready,
    input logic [ROOM_W-1:0]      room,
    input logic [LEVEL_W-1:0]     level
);
    AST_ROOM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        room <= ROOM_W'(ROOM_MAX))
        else $error("room above capacity"); // R10

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LEVEL_W'(LEVEL_MAX))
        else $error("level above capacity"); // R10

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
        (out_valid && $stable(out_data) && $stable(out_keep) && $stable(out_last)))
        else $error("output word changed while waiting"); // R7

    AST_NULL_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        ((KEEP_FILTER != 0) && in_valid && in_ready && (in_keep == '0) && !in_last &&
         !(out_valid && out_ready)) |=> ($stable(room) && $stable(level)))
        else $error("null beat moved a counter"); // R5

    AST_LEVEL_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !(in_valid && in_ready)) |=>
        ((level + LEVEL_W'(1)) == $past(level)))
        else $error("level did not drop by one"); // R9
endmodule

bind stream_width_fifo stream_width_fifo_chk #(
    .IN_BYTES    (IN_BYTES),
    .OUT_BYTES   (OUT_BYTES),
    .LANE_DEPTH  (LANE_DEPTH),
    .KEEP_FILTER (KEEP_FILTER)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_keep   (in_keep),
    .in_last   (in_last),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_data  (out_data),
    .out_keep  (out_keep),
    .out_last  (out_last),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .room      (room),
    .level     (level)
);

// File: tb/test_stream_width_fifo.sv
`timescale 1ns/1ps
module test_stream_width_fifo;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    // narrowing instance: 4 bytes in, 1 byte out, 4 lanes of depth 4
    logic [31:0] n_in_data;  logic [3:0] n_in_keep; logic n_in_last, n_in_valid, n_in_ready;
    logic [7:0]  n_out_data; logic n_out_keep, n_out_last, n_out_valid, n_out_ready;
    logic [2:0]  n_room;     logic [4:0] n_level;
    // widening instance: 1 byte in, 4 bytes out
    logic [7:0]  w_in_data;  logic w_in_keep, w_in_last, w_in_valid, w_in_ready;
    logic [31:0] w_out_data; logic [3:0] w_out_keep; logic w_out_last, w_out_valid, w_out_ready;
    logic [4:0]  w_room;     logic [2:0] w_level;

    stream_width_fifo #(.IN_BYTES(4), .OUT_BYTES(1), .LANE_DEPTH(4), .KEEP_FILTER(1)) i_stream_width_fifo (
        .clk(clk), .rst_n(rst_n), .in_data(n_in_data), .in_keep(n_in_keep), .in_last(n_in_last),
        .in_valid(n_in_valid), .in_ready(n_in_ready), .out_data(n_out_data), .out_keep(n_out_keep),
        .out_last(n_out_last), .out_valid(n_out_valid), .out_ready(n_out_ready),
        .room(n_room), .level(n_level));

    stream_width_fifo #(.IN_BYTES(1), .OUT_BYTES(4), .LANE_DEPTH(4), .KEEP_FILTER(1)) i_stream_width_fifo_up (
        .clk(clk), .rst_n(rst_n), .in_data(w_in_data), .in_keep(w_in_keep), .in_last(w_in_last),
        .in_valid(w_in_valid), .in_ready(w_in_ready), .out_data(w_out_data), .out_keep(w_out_keep),
        .out_last(w_out_last), .out_valid(w_out_valid), .out_ready(w_out_ready),
        .room(w_room), .level(w_level));

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // behavioural reference state
    int n_room_m, n_level_m, n_pops, n_lin, n_lout, w_room_m, w_level_m, w_idx, w_lin, w_lout;
    int zero_last_seen;
    logic [7:0]  nq_d[$]; logic nq_k[$]; logic nq_l[$];
    logic [31:0] wq_d[$]; logic [3:0] wq_k[$]; logic wq_l[$];
    logic [31:0] w_pdata; logic [3:0] w_pkeep;
    bit n_hold, w_hold;
    logic [7:0]  n_hd; logic [31:0] w_hd;

    initial begin : main
        {n_in_data, n_in_keep, n_in_last, n_in_valid, n_out_ready} = '0;
        {w_in_data, w_in_keep, w_in_last, w_in_valid, w_out_ready} = '0;
        n_room_m = 4; n_level_m = 0; n_pops = 0; n_lin = 0; n_lout = 0;
        w_room_m = 16; w_level_m = 0; w_idx = 0; w_lin = 0; w_lout = 0;
        zero_last_seen = 0; w_pdata = '0; w_pkeep = '0; n_hold = 0; w_hold = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state of both instances
        chk(n_room == 3'd4 && n_level == 0, "R1", "narrow room/level", {n_room, n_level}, {3'd4, 5'd0});
        chk(w_room == 5'd16 && w_level == 0, "R1", "widen room/level", {w_room, w_level}, {5'd16, 3'd0});
        chk(n_in_ready && !n_out_valid && w_in_ready && !w_out_valid, "R1", "ready/valid",
            {n_in_ready, n_out_valid, w_in_ready, w_out_valid}, 4'b1010);

        for (int cyc = 0; cyc < 3400; cyc++) begin
            bit nfi, nfo, wfi, wfo;
            if (cyc > 0) @(negedge clk);
            // ---- compare DUT with model (state after the last edge)
            chk(n_in_ready == (n_room_m > 0), "R2", "narrow in_ready", n_in_ready, n_room_m > 0);
            chk(n_out_valid == (n_level_m > 0), "R2", "narrow out_valid", n_out_valid, n_level_m > 0);
            chk(n_room == n_room_m, "R8", "narrow room", n_room, n_room_m);
            chk(n_level == n_level_m, "R9", "narrow level", n_level, n_level_m);
            chk(n_room <= 4 && n_level <= 16, "R10", "narrow bounds", {n_room, n_level}, {3'd4, 5'd16});
            if (n_out_valid && nq_d.size() > 0)
                chk({n_out_data, n_out_keep, n_out_last} == {nq_d[0], nq_k[0], nq_l[0]}, "R3",
                    "narrow word (R5 null beats absent)", {n_out_data, n_out_keep, n_out_last},
                    {nq_d[0], nq_k[0], nq_l[0]});
            if (n_hold)
                chk(n_out_valid && n_out_data == n_hd, "R7", "narrow hold", {n_out_valid, n_out_data}, {1'b1, n_hd});
            chk(w_in_ready == (w_room_m > 0), "R2", "widen in_ready", w_in_ready, w_room_m > 0);
            chk(w_out_valid == (w_level_m > 0), "R2", "widen out_valid", w_out_valid, w_level_m > 0);
            chk(w_room == w_room_m, "R8", "widen room", w_room, w_room_m);
            chk(w_level == w_level_m, "R9", "widen level", w_level, w_level_m);
            chk(w_room <= 16 && w_level <= 4, "R10", "widen bounds", {w_room, w_level}, {5'd16, 3'd4});
            if (w_out_valid && wq_d.size() > 0)
                chk({w_out_data, w_out_keep, w_out_last} == {wq_d[0], wq_k[0], wq_l[0]}, "R4",
                    "widen word", {w_out_data, w_out_keep, w_out_last}, {wq_d[0], wq_k[0], wq_l[0]});
            if (w_hold)
                chk(w_out_valid && w_out_data == w_hd, "R7", "widen hold", {w_out_valid, w_out_data}, {1'b1, w_hd});
            if (cyc == 59)
                chk(!n_in_ready && n_room == 0 && !w_in_ready && w_room == 0, "R10", "full stalls input",
                    {n_in_ready, n_room, w_in_ready, w_room}, 0);

            // ---- drive the next cycle
            if (cyc < 60) begin
                n_in_valid = 1; w_in_valid = 1; n_out_ready = 0; w_out_ready = 0;
            end else if (cyc < 140 || cyc >= 3140) begin
                n_in_valid = 0; w_in_valid = 0; n_out_ready = 1; w_out_ready = 1;
            end else begin
                n_in_valid = ($urandom % 4) != 0; w_in_valid = ($urandom % 4) != 0;
                n_out_ready = ($urandom % 3) != 0; w_out_ready = ($urandom % 5) == 0;
            end
            n_in_data = $urandom; n_in_keep = (($urandom % 3) == 0) ? 4'h0 : 4'($urandom);
            n_in_last = ($urandom % 4) == 0;
            w_in_data = 8'($urandom); w_in_keep = ($urandom % 3) != 0; w_in_last = ($urandom % 4) == 0;
            n_hold = n_out_valid && !n_out_ready; n_hd = n_out_data;
            w_hold = w_out_valid && !w_out_ready; w_hd = w_out_data;
            #1;

            // ---- advance the model across the coming edge
            nfi = n_in_valid && (n_room_m > 0);
            nfo = n_out_ready && (n_level_m > 0);
            if (nfo) begin
                if (nq_l[0]) n_lout++;
                void'(nq_d.pop_front()); void'(nq_k.pop_front()); void'(nq_l.pop_front());
                n_level_m--; n_pops++;
                if (n_pops == 4) begin n_pops = 0; n_room_m++; end
            end
            if (nfi && !(n_in_keep == 0 && !n_in_last)) begin
                if (n_in_last) n_lin++;
                if (n_in_last && n_in_keep == 0) zero_last_seen++;
                for (int b = 0; b < 4; b++) begin
                    nq_d.push_back(n_in_data[8*b +: 8]); nq_k.push_back(n_in_keep[b]);
                    nq_l.push_back(n_in_last && b == 3);
                end
                n_room_m--; n_level_m += 4;
            end
            wfi = w_in_valid && (w_room_m > 0);
            wfo = w_out_ready && (w_level_m > 0);
            if (wfo) begin
                if (wq_l[0]) w_lout++;
                void'(wq_d.pop_front()); void'(wq_k.pop_front()); void'(wq_l.pop_front());
                w_level_m--; w_room_m += 4;
            end
            if (wfi && !(!w_in_keep && !w_in_last)) begin
                if (w_in_last) w_lin++;
                if (w_in_last && !w_in_keep) zero_last_seen++;
                w_pdata[8*w_idx +: 8] = w_in_data; w_pkeep[w_idx] = w_in_keep;
                if (w_in_last || w_idx == 3) begin
                    wq_d.push_back(w_pdata); wq_k.push_back(w_pkeep); wq_l.push_back(w_in_last);
                    w_room_m -= w_in_last ? (4 - w_idx) : 1;
                    w_level_m++; w_pdata = '0; w_pkeep = '0; w_idx = 0;
                end else begin
                    w_idx++; w_room_m--;
                end
            end
        end
        @(negedge clk);
        // R6: every last-flagged beat, including empty ones, came out
        chk(n_lout == n_lin, "R6", "narrow last count", n_lout, n_lin);
        chk(w_lout == w_lin, "R6", "widen last count", w_lout, w_lin);
        chk(zero_last_seen > 0, "R6", "empty last beats exercised", zero_last_seen, 1);
        chk(nq_d.size() == 0 && n_level == 0, "R9", "narrow drained", n_level, 0);
        chk(wq_d.size() == 0 && w_level == 0, "R9", "widen drained", w_level, 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : watchdog
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule